// File: doc/BRIEF.md
# Interrupt Distributor Control Register Block

This block is the register front end for the global side of an interrupt distributor running in a reduced configuration. There is one security state, affinity routing is always on, and only Group 1 interrupts exist. Software reaches it through a 32-bit register bus that uses word offsets. The block keeps an enable bitmap and a pending bitmap for the shared interrupts, which are the interrupts numbered 32 and up. It also stores priority and configuration words that have no effect on behaviour.

It drives two outputs to a downstream selector. The first is the global Group 1 enable. The second is a vector that is the enable bitmap ANDed with the pending bitmap, one bit per interrupt. Fields that this configuration does not support are fixed at one or at zero. The slice of each bitmap that covers the private interrupts (0 to 31) reads as zero and ignores writes.

Top module: `idist_ctrl_regs`

## Requirements
- R1: The control word is at offset 0x000. Bit 4 (routing on) and bit 6 (single security state) always read 1, and writes do not change them. Bit 1 is the Group 1 enable. It is writable, it reads back as written, and `glb_en` follows it from the cycle after the write.
- R2: Bit 0 of the control word is a Group 0 enable that does not exist. Writing 1 to it enables nothing: `glb_en` stays 0 and bit 0 reads 0. A control write with bit 1 at 0 clears `glb_en`.
- R3: The type word is at offset 0x001. Bits 4:0 hold min(NUM_IRQS,1024)/32−1, which is 2 at the default of 96. Bits 23:19 hold 9. All other bits read 0, including the CPU count in bits 7:5 and bits 16 and 17. At the default the word reads 0x00480002, and writes do not change it.
- R4: The identification word is at offset 0x002. It reads PRODUCT in bits 31:24 and IMPLEMENTER in bits 11:0, which is 0x5A0002C1 at the defaults. Writes are ignored.
- R5: The set-enable word n is at 0x040+n and writes 1 to set. The clear-enable word n is at 0x060+n and writes 1 to clear. Both read back the enable bits of interrupts 32n to 32n+31.
- R6: The set-pending word n is at 0x080+n and writes 1 to set. The clear-pending word n is at 0x0A0+n and writes 1 to clear. Both read back the pending bits.
- R7: `irq_pend[i]` equals enable[i] AND pending[i] from the cycle after the write. Bits 31:0 are always 0.
- R8: Word n=0 of all four bitmap regions reads 0. Writes to it change neither `irq_pend` nor any other word.
- R9: The group word n is at 0x020+n. It reads 0xFFFFFFFF for n < NUM_IRQS/32 and ignores writes. The active words at 0x0C0+n and 0x0E0+n read 0 and ignore writes.
- R10: The priority word n is at 0x100+n, for 8 ≤ n < NUM_IRQS/4. The configuration word n is at 0x200+n, for 2 ≤ n < NUM_IRQS/16. Both store and read back full 32-bit words. Words below these ranges read 0 and ignore writes. Neither kind of word affects `irq_pend`.
- R11: Any offset not listed here reads 0, and writes to it change nothing.
- R12: `req_ready` is always 1. An accepted read raises `rsp_valid` with its data for exactly the next cycle. Writes produce no response.
- R13: Synchronous reset clears `glb_en`, both bitmaps and all stored words. After reset the control word reads 0x50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 10 | Word offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| glb_en | output | 1 | Global Group 1 enable |
| irq_pend | output | NUM_IRQS | Enabled-and-pending vector |

## Verification
The bitmaps are driven with sparse masks, with wide masks that overlap bits already set, and with masks that set and clear the same word. These patterns show whether writes really set or clear single bits rather than overwriting the whole word. Separate enable and pending patterns show that `irq_pend` is their AND and not either one alone. Stores of all ones to the private words, to the fixed fields and to unmapped offsets are followed by readback and by a check that `irq_pend` is unchanged. The first and last valid priority words and the words just outside their range are tested, which separates a correct range decode from an off-by-one.

// File: rtl/idist_pkg.sv
package idist_pkg;

    localparam int ADDR_W = 10;
    localparam int IDX_W  = 8;
    localparam int DATA_W = 32;

    localparam int CTRL_G0_BIT     = 0;
    localparam int CTRL_G1_BIT     = 1;
    localparam int CTRL_ROUTE_BIT  = 4;
    localparam int CTRL_ONESEC_BIT = 6;

    localparam int TYPE_IDBITS_LSB = 19;
    localparam int ID_BITS         = 10;

    localparam int PRIO_LO = 8;   // private priority words below this
    localparam int CFG_LO  = 2;   // private config words below this

    typedef enum logic [3:0] {
        RG_NONE,
        RG_CTRL,
        RG_TYPE,
        RG_IDENT,
        RG_GROUP,
        RG_SETEN,
        RG_CLREN,
        RG_SETPD,
        RG_CLRPD,
        RG_PRIO,
        RG_CFG
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } reg_sel_t;

    function automatic logic [DATA_W-1:0] type_word(int n_irqs);
        int capped;
        capped = (n_irqs > 1024) ? 1024 : n_irqs;
        return DATA_W'((capped / 32) - 1) |
               (DATA_W'(ID_BITS - 1) << TYPE_IDBITS_LSB);
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(logic g1);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTRL_ROUTE_BIT]  = 1'b1;
        w[CTRL_ONESEC_BIT] = 1'b1;
        w[CTRL_G1_BIT]     = g1;
        return w;
    endfunction

endpackage

// File: rtl/idist_decode.sv
module idist_decode
    import idist_pkg::*;
#(
    parameter int NUM_IRQS = 96
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam int NW   = NUM_IRQS / 32;
    localparam int NPRI = NUM_IRQS / 4;
    localparam int NCFG = NUM_IRQS / 16;

    logic [4:0] lo;
    logic [4:0] blk;
    int         lo_i;
    int         pri_i;
    int         cfg_i;

    assign lo    = addr[4:0];
    assign blk   = addr[9:5];
    assign lo_i  = int'(lo);
    assign pri_i = int'(addr[7:0]);
    assign cfg_i = int'(addr[5:0]);

    always_comb begin
        sel.kind = RG_NONE;
        sel.idx  = {3'b000, lo};
        if (addr[9:8] == 2'b00) begin
            unique case (blk)
                5'd0: begin
                    if (lo == 5'd0) sel.kind = RG_CTRL;
                    else if (lo == 5'd1) sel.kind = RG_TYPE;
                    else if (lo == 5'd2) sel.kind = RG_IDENT;
                end
                5'd1: if (lo_i < NW) sel.kind = RG_GROUP;
                5'd2: if (lo_i >= 1 && lo_i < NW) sel.kind = RG_SETEN;
                5'd3: if (lo_i >= 1 && lo_i < NW) sel.kind = RG_CLREN;
                5'd4: if (lo_i >= 1 && lo_i < NW) sel.kind = RG_SETPD;
                5'd5: if (lo_i >= 1 && lo_i < NW) sel.kind = RG_CLRPD;
                default: sel.kind = RG_NONE;
            endcase
        end else if (addr[9:8] == 2'b01) begin
            sel.idx = addr[7:0];
            if (pri_i >= PRIO_LO && pri_i < NPRI) sel.kind = RG_PRIO;
        end else if (addr[9:6] == 4'b1000) begin
            sel.idx = {2'b00, addr[5:0]};
            if (cfg_i >= CFG_LO && cfg_i < NCFG) sel.kind = RG_CFG;
        end
    end

endmodule

// File: rtl/idist_bitmap.sv
module idist_bitmap
    import idist_pkg::*;
#(
    parameter int NUM_IRQS = 96
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                set_we,
    input  logic                clr_we,
    input  logic [IDX_W-1:0]    idx,
    input  logic [DATA_W-1:0]   wdata,
    output logic [NUM_IRQS-1:0] bits
);
    localparam int NW = NUM_IRQS / 32;

    assign bits[31:0] = '0;

    for (genvar w = 1; w < NW; w++) begin : g_word
        logic [31:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (idx == IDX_W'(w)) begin
                if (set_we)      word_q <= word_q | wdata;
                else if (clr_we) word_q <= word_q & ~wdata;
            end
        end
        assign bits[w*32 +: 32] = word_q;
    end

endmodule

// File: rtl/idist_wordstore.sv
module idist_wordstore
    import idist_pkg::*;
#(
    parameter int LO = 8,
    parameter int HI = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = HI - LO;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < DEPTH; i++)
                if (idx == IDX_W'(LO + i)) mem_q[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++)
            if (idx == IDX_W'(LO + i)) rdata = mem_q[i];
    end

endmodule

// File: rtl/idist_ctrl_regs.sv
module idist_ctrl_regs
    import idist_pkg::*;
#(
    parameter int          NUM_IRQS    = 96,
    parameter logic [7:0]  PRODUCT     = 8'h5A,
    parameter logic [11:0] IMPLEMENTER = 12'h2C1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                glb_en,
    output logic [NUM_IRQS-1:0] irq_pend
);
    localparam int NW   = NUM_IRQS / 32;
    localparam int NPRI = NUM_IRQS / 4;
    localparam int NCFG = NUM_IRQS / 16;
    localparam logic [DATA_W-1:0] TYPE_VAL  = type_word(NUM_IRQS);
    localparam logic [DATA_W-1:0] IDENT_VAL = {PRODUCT, 12'h000, IMPLEMENTER};

    reg_sel_t              sel;
    logic                  acc;
    logic                  wr;
    logic                  g1_q;
    logic [NUM_IRQS-1:0]   en_bits;
    logic [NUM_IRQS-1:0]   pd_bits;
    logic [DATA_W-1:0]     prio_rd;
    logic [DATA_W-1:0]     cfg_rd;
    logic [DATA_W-1:0]     en_word;
    logic [DATA_W-1:0]     pd_word;
    logic [DATA_W-1:0]     rd_mux;
    logic                  rsp_valid_q;
    logic [DATA_W-1:0]     rsp_rdata_q;

    assign req_ready = 1'b1;
    assign acc       = req_valid & req_ready;
    assign wr        = acc & req_write;

    idist_decode #(.NUM_IRQS(NUM_IRQS)) u_dec (
        .addr (req_addr),
        .sel  (sel)
    );

    idist_bitmap #(.NUM_IRQS(NUM_IRQS)) u_enable (
        .clk    (clk),
        .rst    (rst),
        .set_we (wr && sel.kind == RG_SETEN),
        .clr_we (wr && sel.kind == RG_CLREN),
        .idx    (sel.idx),
        .wdata  (req_wdata),
        .bits   (en_bits)
    );

    idist_bitmap #(.NUM_IRQS(NUM_IRQS)) u_pending (
        .clk    (clk),
        .rst    (rst),
        .set_we (wr && sel.kind == RG_SETPD),
        .clr_we (wr && sel.kind == RG_CLRPD),
        .idx    (sel.idx),
        .wdata  (req_wdata),
        .bits   (pd_bits)
    );

    idist_wordstore #(.LO(PRIO_LO), .HI(NPRI)) u_prio (
        .clk   (clk),
        .rst   (rst),
        .we    (wr && sel.kind == RG_PRIO),
        .idx   (sel.idx),
        .wdata (req_wdata),
        .rdata (prio_rd)
    );

    idist_wordstore #(.LO(CFG_LO), .HI(NCFG)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (wr && sel.kind == RG_CFG),
        .idx   (sel.idx),
        .wdata (req_wdata),
        .rdata (cfg_rd)
    );

    // Group 1 enable: the only writable control bit; Group 0 bit is dropped
    always_ff @(posedge clk) begin
        if (rst)                           g1_q <= 1'b0;
        else if (wr && sel.kind == RG_CTRL) g1_q <= req_wdata[CTRL_G1_BIT];
    end

    always_comb begin
        en_word = '0;
        pd_word = '0;
        for (int w = 0; w < NW; w++) begin
            if (sel.idx == IDX_W'(w)) begin
                en_word = en_bits[w*32 +: 32];
                pd_word = pd_bits[w*32 +: 32];
            end
        end
    end

    always_comb begin
        unique case (sel.kind)
            RG_CTRL:            rd_mux = ctrl_word(g1_q);
            RG_TYPE:            rd_mux = TYPE_VAL;
            RG_IDENT:           rd_mux = IDENT_VAL;
            RG_GROUP:           rd_mux = '1;
            RG_SETEN, RG_CLREN: rd_mux = en_word;
            RG_SETPD, RG_CLRPD: rd_mux = pd_word;
            RG_PRIO:            rd_mux = prio_rd;
            RG_CFG:             rd_mux = cfg_rd;
            default:            rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= acc & ~req_write;
            if (acc & ~req_write) rsp_rdata_q <= rd_mux;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_rdata_q;
    assign glb_en    = g1_q;
    assign irq_pend  = en_bits & pd_bits;

endmodule

// File: rtl/idist_ctrl_chk.sv
module idist_ctrl_chk #(
    parameter int NUM_IRQS = 96
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_ready,
    input logic                req_write,
    input logic [9:0]          req_addr,
    input logic                wr_g1,
    input logic                rsp_valid,
    input logic [31:0]         rsp_rdata,
    input logic                glb_en,
    input logic [NUM_IRQS-1:0] irq_pend
);
    localparam logic [31:0] EXP_TYPE = 32'((NUM_IRQS / 32) - 1) | (32'd9 << 19);

    logic rd_acc;
    assign rd_acc = req_valid && req_ready && !req_write;

    assert_read_latency_R12: assert property (@(posedge clk) disable iff (rst)
        rd_acc |=> rsp_valid);

    assert_rsp_after_read_R12: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(rd_acc));

    assert_ctrl_fixed_ones_R1: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_addr) == 10'h000) |-> (rsp_rdata[4] && rsp_rdata[6]));

    assert_ctrl_g1_matches_R1: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_addr) == 10'h000) |-> (rsp_rdata[1] == glb_en));

    assert_no_group0_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_addr) == 10'h000) |-> !rsp_rdata[0]);

    assert_g1_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write && req_addr == 10'h000 && !wr_g1) |=> !glb_en);

    assert_type_value_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_addr) == 10'h001) |-> (rsp_rdata == EXP_TYPE));

    assert_private_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        irq_pend[31:0] == 32'h0);

    assert_reset_state_R13: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!glb_en && irq_pend == '0 && !rsp_valid));

endmodule

bind idist_ctrl_regs idist_ctrl_chk #(.NUM_IRQS(NUM_IRQS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .wr_g1     (req_wdata[1]),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .glb_en    (glb_en),
    .irq_pend  (irq_pend)
);

// File: tb/tb_idist_ctrl_regs.sv
`timescale 1ns/1ps
module tb_idist_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        glb_en;
    logic [95:0] irq_pend;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    idist_ctrl_regs dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .glb_en    (glb_en),
        .irq_pend  (irq_pend)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic do_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R12 no response to write", {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic do_read(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check("R12 rsp_valid next cycle", {31'b0, rsp_valid}, 32'd1);
        d = rsp_rdata;
        @(negedge clk);
        check("R12 rsp_valid one cycle only", {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic rd_check(input string tag, input logic [9:0] a, input logic [31:0] exp);
        logic [31:0] d;
        do_read(a, d);
        check(tag, d, exp);
    endtask

    task automatic t_reset();
        check("R13 glb_en after reset", {31'b0, glb_en}, 32'd0);
        check("R13 irq_pend low after reset", irq_pend[31:0], 32'd0);
        check("R13 irq_pend mid after reset", irq_pend[63:32], 32'd0);
        check("R13 irq_pend high after reset", irq_pend[95:64], 32'd0);
        check("R13 ready", {31'b0, req_ready}, 32'd1);
        rd_check("R13 ctrl reset value", 10'h000, 32'h50);
        rd_check("R13 enable cleared", 10'h041, 32'h0);
        rd_check("R13 prio cleared", 10'h108, 32'h0);
    endtask

    task automatic t_ctrl();
        do_write(10'h000, 32'h2);
        check("R1 glb_en set", {31'b0, glb_en}, 32'd1);
        rd_check("R1 ctrl with g1", 10'h000, 32'h52);
        do_write(10'h000, 32'h0);
        check("R1 glb_en cleared", {31'b0, glb_en}, 32'd0);
        rd_check("R1 fixed ones survive zero write", 10'h000, 32'h50);
        do_write(10'h000, 32'hFFFF_FFFD);
        check("R2 glb_en with g1 clear", {31'b0, glb_en}, 32'd0);
        rd_check("R1 only g1 writable", 10'h000, 32'h50);
    endtask

    task automatic t_group0();
        do_write(10'h000, 32'h1);
        check("R2 group0 enables nothing", {31'b0, glb_en}, 32'd0);
        rd_check("R2 group0 bit reads zero", 10'h000, 32'h50);
        do_write(10'h000, 32'h3);
        check("R2 g1 set alongside g0", {31'b0, glb_en}, 32'd1);
        rd_check("R2 g0 dropped", 10'h000, 32'h52);
    endtask

    task automatic t_type_ident();
        rd_check("R3 type value", 10'h001, 32'h0048_0002);
        do_write(10'h001, 32'hFFFF_FFFF);
        rd_check("R3 type ignores writes", 10'h001, 32'h0048_0002);
        rd_check("R4 ident value", 10'h002, 32'h5A00_02C1);
        do_write(10'h002, 32'h0);
        rd_check("R4 ident ignores writes", 10'h002, 32'h5A00_02C1);
    endtask

    task automatic t_enable();
        do_write(10'h041, 32'h0000_00F0);
        rd_check("R5 set-enable readback", 10'h041, 32'h0000_00F0);
        rd_check("R5 clear-enable readback", 10'h061, 32'h0000_00F0);
        do_write(10'h041, 32'h0000_0010);
        rd_check("R5 set keeps other bits", 10'h041, 32'h0000_00F0);
        do_write(10'h061, 32'h0000_0030);
        rd_check("R5 clear only ones", 10'h041, 32'h0000_00C0);
        do_write(10'h042, 32'h8000_0001);
        rd_check("R5 word 2", 10'h062, 32'h8000_0001);
        rd_check("R5 word 1 untouched", 10'h041, 32'h0000_00C0);
        check("R7 enable alone gives nothing", irq_pend[63:32], 32'h0);
    endtask

    task automatic t_pending();
        do_write(10'h081, 32'h0000_00C3);
        check("R7 and of enable and pending w1", irq_pend[63:32], 32'h0000_00C0);
        do_write(10'h082, 32'h0000_0003);
        check("R7 and of enable and pending w2", irq_pend[95:64], 32'h0000_0001);
        do_write(10'h0A1, 32'h0000_0040);
        check("R7 after clear-pending", irq_pend[63:32], 32'h0000_0080);
        rd_check("R6 set-pending readback", 10'h081, 32'h0000_0083);
        rd_check("R6 clear-pending readback", 10'h0A1, 32'h0000_0083);
        do_write(10'h061, 32'h0000_0080);
        check("R7 after clear-enable", irq_pend[63:32], 32'h0);
        do_write(10'h041, 32'h0000_0080);
        check("R7 re-enable restores", irq_pend[63:32], 32'h0000_0080);
    endtask

    task automatic t_private();
        do_write(10'h040, 32'hFFFF_FFFF);
        do_write(10'h080, 32'hFFFF_FFFF);
        check("R8 private irq_pend stays zero", irq_pend[31:0], 32'h0);
        check("R8 shared irq_pend untouched", irq_pend[63:32], 32'h0000_0080);
        rd_check("R8 set-enable word0", 10'h040, 32'h0);
        rd_check("R8 clear-enable word0", 10'h060, 32'h0);
        rd_check("R8 set-pending word0", 10'h080, 32'h0);
        rd_check("R8 clear-pending word0", 10'h0A0, 32'h0);
        do_write(10'h060, 32'hFFFF_FFFF);
        do_write(10'h0A0, 32'hFFFF_FFFF);
        rd_check("R8 clear word0 does not alias", 10'h041, 32'h0000_00C0);
        rd_check("R8 clear word0 pending alias", 10'h081, 32'h0000_0083);
    endtask

    task automatic t_group_active();
        for (int n = 0; n < 3; n++)
            rd_check("R9 group reads ones", 10'h020 + 10'(n), 32'hFFFF_FFFF);
        rd_check("R9 group beyond range", 10'h023, 32'h0);
        do_write(10'h021, 32'h0);
        rd_check("R9 group ignores writes", 10'h021, 32'hFFFF_FFFF);
        do_write(10'h0C1, 32'hFFFF_FFFF);
        do_write(10'h0E1, 32'hFFFF_FFFF);
        rd_check("R9 active-set reads zero", 10'h0C1, 32'h0);
        rd_check("R9 active-clear reads zero", 10'h0E1, 32'h0);
        check("R9 active writes no effect", irq_pend[63:32], 32'h0000_0080);
    endtask

    task automatic t_prio_cfg();
        do_write(10'h108, 32'hA5A5_1234);
        do_write(10'h117, 32'h0BAD_F00D);
        rd_check("R10 first priority word", 10'h108, 32'hA5A5_1234);
        rd_check("R10 last priority word", 10'h117, 32'h0BAD_F00D);
        do_write(10'h107, 32'hFFFF_FFFF);
        rd_check("R10 private priority word", 10'h107, 32'h0);
        do_write(10'h118, 32'hFFFF_FFFF);
        rd_check("R10 priority past range", 10'h118, 32'h0);
        do_write(10'h202, 32'hAAAA_5555);
        do_write(10'h205, 32'h1357_9BDF);
        rd_check("R10 config word", 10'h202, 32'hAAAA_5555);
        rd_check("R10 last config word", 10'h205, 32'h1357_9BDF);
        do_write(10'h201, 32'hFFFF_FFFF);
        rd_check("R10 private config word", 10'h201, 32'h0);
        check("R10 no effect on irq_pend", irq_pend[63:32], 32'h0000_0080);
        check("R10 no effect on irq_pend w2", irq_pend[95:64], 32'h0000_0001);
    endtask

    task automatic t_unmapped();
        do_write(10'h003, 32'hFFFF_FFFF);
        rd_check("R11 unmapped low", 10'h003, 32'h0);
        do_write(10'h3FF, 32'hFFFF_FFFF);
        rd_check("R11 unmapped top", 10'h3FF, 32'h0);
        do_write(10'h043, 32'hFFFF_FFFF);
        rd_check("R11 enable word past range", 10'h043, 32'h0);
        rd_check("R11 ctrl unaffected", 10'h000, 32'h52);
        check("R11 glb_en unaffected", {31'b0, glb_en}, 32'd1);
        check("R11 irq_pend unaffected", irq_pend[95:64], 32'h0000_0001);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R13 glb_en cleared by reset", {31'b0, glb_en}, 32'd0);
        check("R13 irq_pend cleared by reset", irq_pend[63:32], 32'h0);
        rd_check("R13 pending cleared", 10'h081, 32'h0);
        rd_check("R13 config cleared", 10'h202, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_group0();
        t_type_ident();
        t_enable();
        t_pending();
        t_private();
        t_group_active();
        t_prio_cfg();
        t_unmapped();
        t_reset_again();
        summary();
        $finish;
    end

endmodule